// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits over several clock cycles using radix-2 Booth recoding. A working register is formed from an accumulator one bit wider than the operands, the multiplier word, and a single trailing bit that starts at zero. On every iteration the block looks at the lowest multiplier bit together with the trailing bit. Depending on that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator unchanged. It then shifts the whole register right by one place and copies the sign into the vacated top bit.

A caller pulses `start` while the unit is idle and presents both operands in that cycle. The unit raises `busy`, runs exactly `WIDTH` iterations at one per clock, then lowers `busy` and pulses `done` for one cycle. The full `2*WIDTH`-bit signed product then appears split across an upper and a lower word. The guard bit of the accumulator is dropped. The result stays on the outputs until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `prod_hi` and `prod_lo` are all zeros.
- R2: A `start` sampled high at a rising edge while `busy` is 0 captures `mcand_in` and `mplier_in`, and `busy` reads 1 after that edge.
- R3: The product {`prod_hi`,`prod_lo`} equals the signed product of the captured multiplicand and multiplier, both taken as two's complement, for every operand pair and in either operand order.
- R4: `busy` stays high for exactly `WIDTH` cycles after the accepting edge, and `done` goes high at the same edge where `busy` falls.
- R5: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R6: `start` and operand changes while `busy` is 1 have no effect on the result or on the completion cycle.
- R7: Operands equal to the most negative value (-2^(WIDTH-1)) in either or both positions give the exact product, including the case (-2^(WIDTH-1))^2.
- R8: `prod_hi` carries bits 2*WIDTH-1 down to WIDTH of the product and `prod_lo` carries bits WIDTH-1 down to 0.
- R9: After completion, `prod_hi` and `prod_lo` hold their values while `start` stays low, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiply; accepted only while idle |
| mcand_in | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier_in | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | WIDTH | Upper half of the signed product |
| prod_lo | output | WIDTH | Lower half of the signed product |

## Verification
At `WIDTH` = 4 the bench runs every ordered pair of operands. This covers every recoding sequence: long runs of ones and zeros, alternating patterns, and the most negative value in both positions. Running each pair in both orders separates a correct sign-extending shift from one that only works for a positive multiplier. Some runs pulse `start` and change the operands while busy, which shows whether a stray start is taken as a reload. Other runs change the inputs after completion, which shows whether the result registers are held or recomputed.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    output booth_op_e  op
);

    always_comb begin
        case (pair)
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] mcand,
    input  booth_op_e     op,
    output logic [AW-1:0] sum
);

    always_comb begin
        case (op)
            OP_ADD:  sum = acc + mcand;
            OP_SUB:  sum = acc - mcand;
            default: sum = acc;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);

    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    assign load = start && !ctrl_q.busy;
    assign step = ctrl_q.busy;
    assign busy = ctrl_q.busy;
    assign done = ctrl_q.done;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (load) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.cnt  = '0;
        end else if (ctrl_q.busy) begin
            if (ctrl_q.cnt == LAST) begin
                ctrl_d.busy = 1'b0;
                ctrl_d.done = 1'b1;
            end else begin
                ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |-> !ctrl_q.busy);

    assert_finish_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && ctrl_q.cnt == LAST) |=> (ctrl_q.done && !ctrl_q.busy));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ctrl_q.busy) |=> ctrl_q.busy);

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand_in,
    input  logic [WIDTH-1:0] mplier_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);

    localparam int AW = WIDTH + 1;

    typedef struct packed {
        logic [AW-1:0]    acc;
        logic [WIDTH-1:0] mlo;
        logic             xbit;
        logic [AW-1:0]    mcand;
    } dp_s;

    dp_s dp_d, dp_q;

    logic          load, step;
    booth_op_e     op;
    logic [AW-1:0] sum;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    booth_recoder u_rec (
        .pair ({dp_q.mlo[0], dp_q.xbit}),
        .op   (op)
    );

    booth_addsub #(.AW(AW)) u_add (
        .acc   (dp_q.acc),
        .mcand (dp_q.mcand),
        .op    (op),
        .sum   (sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.acc   = '0;
            dp_d.mlo   = mplier_in;
            dp_d.xbit  = 1'b0;
            dp_d.mcand = {mcand_in[WIDTH-1], mcand_in};
        end else if (step) begin
            dp_d.acc  = {sum[AW-1], sum[AW-1:1]};
            dp_d.mlo  = {sum[0], dp_q.mlo[WIDTH-1:1]};
            dp_d.xbit = dp_q.mlo[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign prod_hi = dp_q.acc[WIDTH-1:0];
    assign prod_lo = dp_q.mlo;

    assert_mcand_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dp_q.mcand));

    assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({prod_hi, prod_lo}));

    assert_guard_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dp_q.acc[WIDTH] == dp_q.acc[WIDTH-1]));

endmodule

// File: tb/sim_booth_seq_mult.sv
`timescale 1ns/1ps
module sim_booth_seq_mult;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] ma = '0;
    logic [W-1:0] mb = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mcand_in  (ma),
        .mplier_in (mb),
        .busy      (busy),
        .done      (done),
        .prod_hi   (hi),
        .prod_lo   (lo)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[2*W-1:0];
    endfunction

    task automatic do_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit disturb, input bit holdchk, input string tag);
        logic [2*W-1:0] exp;
        bit timing_ok;
        exp = ref_prod(a, b);
        @(negedge clk);
        start = 1'b1; ma = a; mb = b;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && done === 1'b0, "R2 busy after start", busy, 1);
        timing_ok = 1'b1;
        for (int i = 1; i <= W; i++) begin
            if (disturb && i == 1) begin
                start = 1'b1; ma = ~a; mb = b + 1'b1;
            end
            if (disturb && i == 2) start = 1'b0;
            @(negedge clk);
            if (i < W) begin
                if (!(busy === 1'b1 && done === 1'b0)) timing_ok = 1'b0;
            end else begin
                if (!(busy === 1'b0 && done === 1'b1)) timing_ok = 1'b0;
            end
        end
        check(timing_ok, disturb ? "R6 R4 completion cycle" : "R4 R5 completion cycle",
              {busy, done}, 1);
        check({hi, lo} === exp, tag, {hi, lo}, exp);
        if (disturb) check({hi, lo} === exp, "R6 start while busy ignored", {hi, lo}, exp);
        if (holdchk) begin
            ma = ~a; mb = ~b;
            @(negedge clk);
            check(done === 1'b0 && busy === 1'b0, "R5 single done pulse", done, 0);
            @(negedge clk);
            check(hi === exp[2*W-1:W], "R9 R8 hi held", hi, exp[2*W-1:W]);
            check(lo === exp[W-1:0], "R9 R8 lo held", lo, exp[W-1:0]);
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #7;
        check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
        check(hi === '0 && lo === '0, "R1 reset product", {hi, lo}, 0);
        rst_n = 1'b1;
        // R3 named cases: 5 x -3 and -8 x 6
        do_mult(4'd5, 4'b1101, 1'b0, 1'b1, "R3 5*-3");
        do_mult(4'b1000, 4'd6, 1'b0, 1'b1, "R3 -8*6");
        // R7 most negative in both positions
        do_mult(4'b1000, 4'b1000, 1'b0, 1'b1, "R7 min*min");
        do_mult(4'b1000, 4'b0111, 1'b0, 1'b0, "R7 min*max");
        do_mult(4'b0111, 4'b1000, 1'b0, 1'b0, "R7 max*min");
        // R3 exhaustive sweep over all ordered pairs
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
                do_mult(4'(ai), 4'(bi), ((ai + bi) % 7) == 0, bi == 3, "R3 R8 product");
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule